// File: doc/BRIEF.md
# SDRAM Command Decoder and State Checker

This block watches the control pins of a single-data-rate SDRAM on the device side. On every rising clock edge it samples the clock-enable, chip-select, row strobe, column strobe, write enable, bank address and address bit 10. It turns these into one command code and follows a reduced model of the device: idle, one open row, a read burst in flight, self refresh, the wake-up window after self refresh, power down and deep power down. Any command that is not allowed in the current state raises a strobe. The command is still reported when the strobe rises, but the model's state stays where it was.

The clock-enable level at the previous edge and at the current edge decides whether the pins carry a normal command, enter a low-power mode, hold one, or leave it. When clock-enable falls, the row/column/write pattern picks the mode. The pattern that would otherwise mean burst stop enters deep power down. With clock-enable steady high, that pattern is reserved and therefore illegal. All outputs are registered, so they describe the command sampled at the edge just before.

Top module: `sdram_cmd_checker`

## Requirements
- R1: With clock-enable high on the previous and current edges and chip select low, {ras,cas,we} decodes as follows: 111 gives NOP (code 0), 011 gives ACT (3), 101 gives RD (4), 100 gives WR (5), 010 gives PRE (6) and 001 gives AREF (7). The pattern 110 gives RSVD (13), which is illegal in every state.
- R2: A high chip select with clock-enable steady high is reported as NOP (0) and changes nothing.
- R3: The 000 pattern gives MRS (1) when the bank address is 0 and EMRS (2) when it is 1. Any other bank value gives RSVD (13).
- R4: auto_pre_o is high only for RD or WR with a10 high. pre_all_o is high only for PRE with a10 high.
- R5: When clock-enable goes from high to low, pattern 001 gives SREF entry (8), pattern 110 gives DPD entry (9), and anything else (including chip select high) gives PD entry (10). When clock-enable was low at the previous edge, a low current edge gives HOLD (12) and a high one gives EXIT (11).
- R6: State codes are IDLE=0, ACTIVE=1, READ=2, SREF=3, WAKE=4, PDOWN=5 and DPD=6. In IDLE, RD and WR are illegal. PRE is accepted and does nothing. MRS, EMRS and AREF are accepted. ACT moves to ACTIVE and records the bank.
- R7: In ACTIVE, MRS, EMRS, AREF and ACT are illegal. WR keeps ACTIVE and RD moves to READ. PRE returns to IDLE only when a10 is high or the bank matches the recorded bank; otherwise the state stays ACTIVE.
- R8: In READ, NOP or deselect continues the burst, RD restarts it, WR moves to ACTIVE, and PRE ends the burst (IDLE if it closes the recorded bank, else ACTIVE). MRS, EMRS, AREF and ACT are illegal.
- R9: illegal_o is high for the one cycle that follows an illegal command, and the state does not change on that command.
- R10: After a self-refresh exit the state is WAKE. Only NOP or deselect is legal there. After NOP_CNT (default 2) of them the state becomes IDLE. An illegal command does not advance the count.
- R11: EXIT from PDOWN returns to the state that was active at entry (IDLE, ACTIVE or READ). EXIT from DPD goes to IDLE.
- R12: The asynchronous reset forces state IDLE, command NOP and all strobes low, and sets the remembered clock-enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock, rising edge samples |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cke_i | input | 1 | Clock-enable pin |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | BA_W | Bank address |
| a10_i | input | 1 | Address bit 10 (auto-precharge / all-banks qualifier) |
| cmd_o | output | 4 | Decoded command code of the last edge |
| illegal_o | output | 1 | One-cycle strobe for a command illegal in its state |
| state_o | output | 3 | Tracked device state |
| auto_pre_o | output | 1 | Last command was a read or write with auto-precharge |
| pre_all_o | output | 1 | Last command was a precharge of all banks |

## Verification
Two things can be decided at the same edge: entering a low-power mode, and judging whether the command bits are legal. This happens because a falling clock-enable turns the refresh pattern into self-refresh entry and the burst-stop pattern into deep power-down entry. The bench drives clock-enable low together with the refresh pattern twice. In IDLE it expects code 8, no strobe and state SREF. In ACTIVE it expects code 8, a strobe, and a state that stays ACTIVE. It then checks that a following rising clock-enable is reported as EXIT without disturbing ACTIVE. The same edge collision is provoked on the read path, where a precharge both ends a burst and may close the tracked bank.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_MRS  = 4'd1,
    CMD_EMRS = 4'd2,
    CMD_ACT  = 4'd3,
    CMD_RD   = 4'd4,
    CMD_WR   = 4'd5,
    CMD_PRE  = 4'd6,
    CMD_AREF = 4'd7,
    CMD_SREF = 4'd8,
    CMD_DPD  = 4'd9,
    CMD_PD   = 4'd10,
    CMD_EXIT = 4'd11,
    CMD_HOLD = 4'd12,
    CMD_RSVD = 4'd13
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ACTIVE = 3'd1,
    ST_READ   = 3'd2,
    ST_SREF   = 3'd3,
    ST_WAKE   = 3'd4,
    ST_PDOWN  = 3'd5,
    ST_DPD    = 3'd6
  } state_e;

  // {ras_n, cas_n, we_n} patterns
  localparam logic [2:0] PAT_MRS  = 3'b000;
  localparam logic [2:0] PAT_REF  = 3'b001;
  localparam logic [2:0] PAT_PRE  = 3'b010;
  localparam logic [2:0] PAT_ACT  = 3'b011;
  localparam logic [2:0] PAT_WR   = 3'b100;
  localparam logic [2:0] PAT_RD   = 3'b101;
  localparam logic [2:0] PAT_STOP = 3'b110;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_chk_pkg::*;
#(
  parameter int BA_W = 2
) (
  input  logic            cke_q_i,
  input  logic            cke_i,
  input  logic            cs_ni,
  input  logic            ras_ni,
  input  logic            cas_ni,
  input  logic            we_ni,
  input  logic [BA_W-1:0] ba_i,
  input  logic            a10_i,
  output cmd_e            cmd_o,
  output logic            auto_pre_o,
  output logic            pre_all_o
);

  logic [2:0] pat;
  cmd_e       base;

  assign pat = {ras_ni, cas_ni, we_ni};

  always_comb begin
    unique case (pat)
      PAT_MRS:  base = (ba_i == BA_W'(0)) ? CMD_MRS :
                       (ba_i == BA_W'(1)) ? CMD_EMRS : CMD_RSVD;
      PAT_REF:  base = CMD_AREF;
      PAT_PRE:  base = CMD_PRE;
      PAT_ACT:  base = CMD_ACT;
      PAT_WR:   base = CMD_WR;
      PAT_RD:   base = CMD_RD;
      PAT_STOP: base = CMD_RSVD;  // burst-stop pattern reserved while CKE steady
      default:  base = CMD_NOP;
    endcase
  end

  always_comb begin
    if (!cke_q_i)      cmd_o = cke_i ? CMD_EXIT : CMD_HOLD;
    else if (cs_ni)    cmd_o = cke_i ? CMD_NOP : CMD_PD;
    else if (cke_i)    cmd_o = base;
    else if (pat == PAT_REF)  cmd_o = CMD_SREF;
    else if (pat == PAT_STOP) cmd_o = CMD_DPD;
    else               cmd_o = CMD_PD;
  end

  assign auto_pre_o = ((cmd_o == CMD_RD) || (cmd_o == CMD_WR)) && a10_i;
  assign pre_all_o  = (cmd_o == CMD_PRE) && a10_i;

endmodule

// File: rtl/sdram_state_track.sv
module sdram_state_track
  import sdram_chk_pkg::*;
#(
  parameter int BA_W    = 2,
  parameter int NOP_CNT = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  cmd_e            cmd_i,
  input  logic [BA_W-1:0] ba_i,
  input  logic            pre_all_i,
  output state_e          state_o,
  output logic            bad_o
);

  localparam int CNT_W = (NOP_CNT > 1) ? $clog2(NOP_CNT + 1) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NOP_CNT - 1);

  state_e            state_q, ret_q, nxt;
  logic [BA_W-1:0]   bank_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              bad, hit;

  assign hit = pre_all_i || (ba_i == bank_q);

  always_comb begin
    nxt = state_q;
    bad = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        unique case (cmd_i)
          CMD_NOP, CMD_PRE, CMD_AREF, CMD_MRS, CMD_EMRS,
          CMD_HOLD, CMD_EXIT: ;
          CMD_ACT:  nxt = ST_ACTIVE;
          CMD_PD:   nxt = ST_PDOWN;
          CMD_SREF: nxt = ST_SREF;
          CMD_DPD:  nxt = ST_DPD;
          default:  bad = 1'b1;
        endcase
      end
      ST_ACTIVE, ST_READ: begin
        unique case (cmd_i)
          CMD_NOP, CMD_HOLD, CMD_EXIT: ;
          CMD_RD:  nxt = ST_READ;
          CMD_WR:  nxt = ST_ACTIVE;
          CMD_PRE: nxt = hit ? ST_IDLE : ST_ACTIVE;
          CMD_PD:  nxt = ST_PDOWN;
          default: bad = 1'b1;
        endcase
      end
      ST_SREF: begin
        if (cmd_i == CMD_EXIT)      nxt = ST_WAKE;
        else if (cmd_i != CMD_HOLD) bad = 1'b1;
      end
      ST_WAKE: begin
        if (cmd_i != CMD_NOP)       bad = 1'b1;
        else if (cnt_q == CNT_LAST) nxt = ST_IDLE;
      end
      ST_PDOWN: begin
        if (cmd_i == CMD_EXIT)      nxt = ret_q;
        else if (cmd_i != CMD_HOLD) bad = 1'b1;
      end
      ST_DPD: begin
        if (cmd_i == CMD_EXIT)      nxt = ST_IDLE;
        else if (cmd_i != CMD_HOLD) bad = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ret_q   <= ST_IDLE;
      bank_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= nxt;
      if (!bad && state_q == ST_IDLE && cmd_i == CMD_ACT) bank_q <= ba_i;
      if (!bad && cmd_i == CMD_PD) ret_q <= state_q;
      if (state_q == ST_SREF) cnt_q <= '0;
      else if (state_q == ST_WAKE && !bad)
        cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + CNT_W'(1);
    end
  end

  assign state_o = state_q;
  assign bad_o   = bad;

endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
  import sdram_chk_pkg::*;
#(
  parameter int BA_W    = 2,
  parameter int NOP_CNT = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cke_i,
  input  logic            cs_ni,
  input  logic            ras_ni,
  input  logic            cas_ni,
  input  logic            we_ni,
  input  logic [BA_W-1:0] ba_i,
  input  logic            a10_i,
  output logic [3:0]      cmd_o,
  output logic            illegal_o,
  output logic [2:0]      state_o,
  output logic            auto_pre_o,
  output logic            pre_all_o
);

  logic   cke_q;
  cmd_e   dec_cmd;
  logic   dec_ap, dec_pa, bad;
  state_e trk_state;
  cmd_e   cmd_q;
  logic   ill_q, ap_q, pa_q;

  sdram_cmd_decode #(.BA_W(BA_W)) u_dec (
    .cke_q_i   (cke_q),
    .cke_i     (cke_i),
    .cs_ni     (cs_ni),
    .ras_ni    (ras_ni),
    .cas_ni    (cas_ni),
    .we_ni     (we_ni),
    .ba_i      (ba_i),
    .a10_i     (a10_i),
    .cmd_o     (dec_cmd),
    .auto_pre_o(dec_ap),
    .pre_all_o (dec_pa)
  );

  sdram_state_track #(.BA_W(BA_W), .NOP_CNT(NOP_CNT)) u_trk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (dec_cmd),
    .ba_i     (ba_i),
    .pre_all_i(dec_pa),
    .state_o  (trk_state),
    .bad_o    (bad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q <= 1'b1;
      cmd_q <= CMD_NOP;
      ill_q <= 1'b0;
      ap_q  <= 1'b0;
      pa_q  <= 1'b0;
    end else begin
      cke_q <= cke_i;
      cmd_q <= dec_cmd;
      ill_q <= bad;
      ap_q  <= dec_ap;
      pa_q  <= dec_pa;
    end
  end

  assign cmd_o      = cmd_q;
  assign illegal_o  = ill_q;
  assign state_o    = trk_state;
  assign auto_pre_o = ap_q;
  assign pre_all_o  = pa_q;

endmodule

// File: rtl/sdram_cmd_checker_sva.sv
module sdram_cmd_checker_sva
  import sdram_chk_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] cmd_o,
  input logic       illegal_o,
  input logic [2:0] state_o,
  input logic       auto_pre_o,
  input logic       pre_all_o
);

  a_r9_state_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> state_o == $past(state_o));

  a_r4_pre_all_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_all_o |-> cmd_o == CMD_PRE);

  a_r4_auto_pre_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_pre_o |-> (cmd_o == CMD_RD || cmd_o == CMD_WR));

  a_r6_rw_in_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == ST_IDLE && (cmd_o == CMD_RD || cmd_o == CMD_WR)) |-> illegal_o);

  a_r10_wake_leave: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == ST_WAKE && state_o != ST_WAKE) |-> cmd_o == CMD_NOP);

  a_r8_read_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_READ && $past(state_o) != ST_READ) |-> (cmd_o == CMD_RD || cmd_o == CMD_EXIT));

  a_r5_dpd_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_DPD && $past(state_o) != ST_DPD) |-> cmd_o == CMD_DPD);

endmodule

bind sdram_cmd_checker sdram_cmd_checker_sva u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmd_o     (cmd_o),
  .illegal_o (illegal_o),
  .state_o   (state_o),
  .auto_pre_o(auto_pre_o),
  .pre_all_o (pre_all_o)
);

// File: tb/sdram_cmd_checker_tb.sv
module sdram_cmd_checker_tb;

  // command codes (R1, R3, R5)
  localparam int NOP = 0, MRS = 1, EMRS = 2, ACT = 3, RD = 4, WR = 5, PRE = 6,
                 AREF = 7, SREF = 8, DPD = 9, PD = 10, EXIT = 11, HOLD = 12, RSVD = 13;
  // state codes (R6)
  localparam int SI = 0, SA = 1, SR = 2, SS = 3, SW = 4, SP = 5, SD = 6;
  // {ras,cas,we}
  localparam logic [2:0] P_NOP = 3'b111, P_MRS = 3'b000, P_REF = 3'b001, P_PRE = 3'b010,
                         P_ACT = 3'b011, P_WR = 3'b100, P_RD = 3'b101, P_STP = 3'b110;

  typedef struct packed {
    logic       cke, cs;
    logic [2:0] pat;
    logic [1:0] ba;
    logic       a10;
    logic [3:0] cmd;
    logic       ill;
    logic [2:0] st;
    logic       ap, pa;
    logic [3:0] req;
  } vec_t;

  function automatic vec_t mk(input logic cke, input logic cs, input logic [2:0] pat,
                              input int ba, input logic a10, input int cmd, input logic ill,
                              input int st, input logic ap, input logic pa, input int req);
    mk = '{cke, cs, pat, 2'(ba), a10, 4'(cmd), ill, 3'(st), ap, pa, 4'(req)};
  endfunction

  localparam int NV = 47;
  localparam vec_t VEC [NV] = '{
    mk(1,0,P_NOP,0,0, NOP, 0,SI,0,0, 1),   // R1 nop
    mk(1,1,P_MRS,0,0, NOP, 0,SI,0,0, 2),   // R2 inhibit
    mk(1,0,P_RD ,0,0, RD,  1,SI,0,0, 6),   // R6 read in idle
    mk(1,0,P_WR ,0,1, WR,  1,SI,1,0, 6),   // R6 write in idle, R4 ap
    mk(1,0,P_PRE,0,1, PRE, 0,SI,0,1, 6),   // R6 precharge no-op, R4 all
    mk(1,0,P_MRS,0,0, MRS, 0,SI,0,0, 3),   // R3 mode reg
    mk(1,0,P_MRS,1,0, EMRS,0,SI,0,0, 3),   // R3 ext mode reg
    mk(1,0,P_MRS,2,0, RSVD,1,SI,0,0, 3),   // R3 bad bank
    mk(1,0,P_REF,0,0, AREF,0,SI,0,0, 1),   // R1 auto refresh
    mk(1,0,P_STP,0,0, RSVD,1,SI,0,0, 1),   // R1 stop pattern reserved
    mk(1,0,P_ACT,1,0, ACT, 0,SA,0,0, 6),   // R6 activate bank 1
    mk(1,0,P_ACT,1,0, ACT, 1,SA,0,0, 7),   // R7
    mk(1,0,P_MRS,0,0, MRS, 1,SA,0,0, 7),   // R7
    mk(1,0,P_REF,0,0, AREF,1,SA,0,0, 7),   // R7
    mk(1,0,P_PRE,0,0, PRE, 0,SA,0,0, 7),   // R7 other bank
    mk(1,0,P_WR ,1,1, WR,  0,SA,1,0, 7),   // R7
    mk(1,0,P_RD ,1,0, RD,  0,SR,0,0, 7),   // R7
    mk(1,0,P_NOP,0,0, NOP, 0,SR,0,0, 8),   // R8
    mk(1,1,P_NOP,0,0, NOP, 0,SR,0,0, 8),   // R8
    mk(1,0,P_ACT,0,0, ACT, 1,SR,0,0, 8),   // R8
    mk(1,0,P_REF,0,0, AREF,1,SR,0,0, 8),   // R8
    mk(1,0,P_RD ,1,1, RD,  0,SR,1,0, 8),   // R8
    mk(1,0,P_WR ,1,0, WR,  0,SA,0,0, 8),   // R8
    mk(1,0,P_RD ,1,0, RD,  0,SR,0,0, 8),   // R8
    mk(1,0,P_PRE,0,0, PRE, 0,SA,0,0, 8),   // R8 ends burst, other bank
    mk(1,0,P_RD ,1,0, RD,  0,SR,0,0, 8),   // R8
    mk(1,0,P_PRE,1,0, PRE, 0,SI,0,0, 8),   // R8 closes bank
    mk(1,0,P_ACT,2,0, ACT, 0,SA,0,0, 7),   // R7
    mk(1,0,P_PRE,0,1, PRE, 0,SI,0,1, 7),   // R7 all banks
    mk(0,0,P_NOP,0,0, PD,  0,SP,0,0, 5),   // R5 power down
    mk(0,0,P_RD ,0,1, HOLD,0,SP,0,0, 5),   // R5 hold
    mk(1,1,P_NOP,0,0, EXIT,0,SI,0,0, 11),  // R11
    mk(1,0,P_ACT,0,0, ACT, 0,SA,0,0, 7),   // R7
    mk(0,1,P_NOP,0,0, PD,  0,SP,0,0, 5),   // R5
    mk(1,1,P_NOP,0,0, EXIT,0,SA,0,0, 11),  // R11 back to active
    mk(0,0,P_REF,0,0, SREF,1,SA,0,0, 9),   // R9 sref in active
    mk(1,0,P_NOP,0,0, EXIT,0,SA,0,0, 5),   // R5 exit, no change
    mk(1,0,P_PRE,0,1, PRE, 0,SI,0,1, 7),   // R7
    mk(0,0,P_REF,0,0, SREF,0,SS,0,0, 5),   // R5 self refresh
    mk(0,1,P_NOP,0,0, HOLD,0,SS,0,0, 5),   // R5
    mk(1,1,P_NOP,0,0, EXIT,0,SW,0,0, 10),  // R10
    mk(1,0,P_ACT,0,0, ACT, 1,SW,0,0, 10),  // R10
    mk(1,0,P_NOP,0,0, NOP, 0,SW,0,0, 10),  // R10
    mk(1,1,P_NOP,0,0, NOP, 0,SI,0,0, 10),  // R10
    mk(0,0,P_STP,0,0, DPD, 0,SD,0,0, 5),   // R5 deep power down
    mk(0,1,P_NOP,0,0, HOLD,0,SD,0,0, 5),   // R5
    mk(1,1,P_NOP,0,0, EXIT,0,SI,0,0, 11)   // R11
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0] ba = '0;
  logic [3:0] cmd;
  logic       ill, ap, pa;
  logic [2:0] st;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  sdram_cmd_checker #(.BA_W(2), .NOP_CNT(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .a10_i(a10),
    .cmd_o(cmd), .illegal_o(ill), .state_o(st), .auto_pre_o(ap), .pre_all_o(pa)
  );

  task automatic drive(input vec_t v);
    cke = v.cke; cs_n = v.cs; {ras_n, cas_n, we_n} = v.pat; ba = v.ba; a10 = v.a10;
  endtask

  task automatic check(input string tag, input int idx, input vec_t v);
    n_chk++;
    if (cmd !== v.cmd || ill !== v.ill || st !== v.st || ap !== v.ap || pa !== v.pa) begin
      n_fail++;
      $display("FAIL %s step %0d: got cmd=%0d ill=%0b st=%0d ap=%0b pa=%0b exp cmd=%0d ill=%0b st=%0d ap=%0b pa=%0b",
               tag, idx, cmd, ill, st, ap, pa, v.cmd, v.ill, v.st, v.ap, v.pa);
    end
  endtask

  initial begin
    #3;
    check("R12", -1, mk(1,1,P_NOP,0,0, NOP,0,SI,0,0, 12));  // R12 reset state
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check($sformatf("R%0d", VEC[i].req), i, VEC[i]);
    end
    // R12: reset in the middle of a row-open phase
    drive(mk(1,0,P_ACT,3,0, ACT,0,SA,0,0, 12));
    @(negedge clk);
    check("R12", 100, mk(1,0,P_ACT,3,0, ACT,0,SA,0,0, 12));
    drive(mk(1,1,P_NOP,0,0, NOP,0,SI,0,0, 12));
    #2 rst_n = 1'b0;
    #1 check("R12", 101, mk(1,1,P_NOP,0,0, NOP,0,SI,0,0, 12));
    @(negedge clk); rst_n = 1'b1;
    drive(mk(1,0,P_RD,0,0, RD,1,SI,0,0, 12));
    @(negedge clk);
    check("R12", 102, mk(1,0,P_RD,0,0, RD,1,SI,0,0, 12));    // idle after reset
    // R9: strobe lasts one cycle
    drive(mk(1,0,P_NOP,0,0, NOP,0,SI,0,0, 9));
    @(negedge clk);
    check("R9", 103, mk(1,0,P_NOP,0,0, NOP,0,SI,0,0, 9));
    // R11: power down entered from a read burst returns to READ
    drive(mk(1,0,P_ACT,0,0, ACT,0,SA,0,0, 11)); @(negedge clk);
    drive(mk(1,0,P_RD ,0,0, RD ,0,SR,0,0, 11)); @(negedge clk);
    drive(mk(0,1,P_NOP,0,0, PD ,0,SP,0,0, 11)); @(negedge clk);
    check("R11", 104, mk(0,1,P_NOP,0,0, PD,0,SP,0,0, 11));
    drive(mk(1,1,P_NOP,0,0, EXIT,0,SR,0,0, 11)); @(negedge clk);
    check("R11", 105, mk(1,1,P_NOP,0,0, EXIT,0,SR,0,0, 11));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R12: run incomplete, got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule